// File: doc/BRIEF.md
# Per-Source Port Knocking Filter

This block is a stateful packet filter that sits in a header-processing path. It keeps a small finite-state machine for every IPv4 source address it sees. A source that sends packets to a fixed sequence of four destination ports, in order, unlocks one service port for itself alone. Every other traffic pattern is dropped. For each packet header, the block finds the source's current state in an associative state table, applies one shared transition function to the pair of that state and the destination port, and writes the resulting state back. It then emits a forward or drop verdict.

Headers enter on a valid/ready stream. Verdicts leave on a second valid/ready stream, two clock edges after acceptance and in arrival order. The state table has a fixed number of entries. A source that has not been seen before is treated as being in the idle state and is given a free entry. Once every entry is taken, packets from new sources are dropped and no entry is created for them. Each packet sees the state written by the packet just ahead of it, even when that write has not yet reached the table.

Top module: `knock_filter`

## Requirements
- R1: After reset no verdict is pending (out_valid low), in_ready is high, and every source is in the idle state.
- R2: A source advances one step per correct knock through the destination-port sequence 5123, 6234, 7345, 8456 and reaches the open state after the fourth. Every knock packet, correct or not, gets a drop verdict (out_fwd = 0).
- R3: While a source is partway through the sequence, a packet to any port other than the next expected knock is dropped and returns that source to the idle state, so the sequence must restart from 5123.
- R4: A source in the open state that sends to port 22 gets a forward verdict (out_fwd = 1) and stays open, so repeated packets to port 22 are all forwarded.
- R5: A source in the open state that sends to any port other than 22 is dropped and goes back to the idle state. Its next packet to port 22 is then dropped.
- R6: A packet to port 22 from a source that is not open is dropped.
- R7: Sources are independent. Interleaving the packets of several sources does not change the verdicts each source would receive on its own.
- R8: A source with no table entry is treated as idle and is given a free entry, so it can then complete the sequence and open.
- R9: With all ENTRIES (default 16) table entries taken, every packet from a new source is dropped and creates no state, so even a full correct sequence followed by port 22 is dropped. Sources already in the table keep working.
- R10: A packet accepted on the cycle right after another packet from the same source uses the state that the earlier packet produced.
- R11: With out_ready held high the block accepts one header per cycle (in_ready stays high). Each verdict appears on out_valid two clock edges after acceptance, in acceptance order.
- R12: While out_valid is high and out_ready is low, out_valid and out_fwd hold their values. With a second header already waiting inside, in_ready is low.
- R13: A source address occupies at most one table entry at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A header is offered |
| in_ready | output | 1 | The block takes the offered header this cycle |
| in_src | input | ADDR_W (32) | Source IPv4 address of the header |
| in_dport | input | PORT_W (16) | Destination port of the header |
| out_valid | output | 1 | A verdict is presented |
| out_ready | input | 1 | The consumer takes the verdict this cycle |
| out_fwd | output | 1 | Verdict: 1 forward, 0 drop |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16-bit ports, the 5123/6234/7345/8456 sequence with service port 22, and 16 table entries. With a 16-entry table, four directed sources plus a random pool of twelve fill the store within a few hundred packets. A seventeenth source then reaches the table-full path in the same short run. Back-to-back headers from one source and a random consumer stall pattern drive the write-forwarding path and the hold behaviour.

// File: rtl/knock_pkg.sv
// Shared types for the per-source port knocking filter.
// Assumes nothing beyond the state encoding below.
package knock_pkg;
    // Per-source state; the numeric values are also the step index
    // used to pick the expected knock port.
    typedef enum logic [2:0] {
        KS_IDLE = 3'd0,
        KS_K1   = 3'd1,
        KS_K2   = 3'd2,
        KS_K3   = 3'd3,
        KS_OPEN = 3'd4
    } kstate_t;
endpackage

// File: rtl/knock_xfsm.sv
// Shared transition function: maps {current state, destination port}
// to {next state, forward}. Purely combinational.
// Assumes KNOCK_SEQ holds four ports, step 0 in the low slice.
module knock_xfsm
    import knock_pkg::*;
#(
    parameter int                   PORT_W    = 16,
    parameter logic [4*PORT_W-1:0]  KNOCK_SEQ = {16'd8456, 16'd7345, 16'd6234, 16'd5123},
    parameter logic [PORT_W-1:0]    SVC_PORT  = 16'd22
) (
    input  kstate_t             cur_state,
    input  logic [PORT_W-1:0]   dport,
    output kstate_t             nxt_state,
    output logic                fwd
);
    localparam int STEPS = 4;

    logic [STEPS-1:0] knock_match;
    logic [2:0]       cur_b;

    assign cur_b = cur_state;

    // One comparator per knock step.
    for (genvar g = 0; g < STEPS; g++) begin : g_step
        assign knock_match[g] = (dport == KNOCK_SEQ[g*PORT_W +: PORT_W]);
    end

    // Select the next state and the verdict.
    always_comb begin
        nxt_state = KS_IDLE;
        fwd       = 1'b0;
        if (cur_state == KS_OPEN) begin
            if (dport == SVC_PORT) begin
                nxt_state = KS_OPEN;
                fwd       = 1'b1;
            end
        end else if (cur_b[2] == 1'b0) begin
            if (knock_match[cur_b[1:0]]) begin
                nxt_state = kstate_t'(cur_b + 3'd1);
            end
        end
    end
endmodule

// File: rtl/knock_state_table.sv
// Small associative store of {source key, state} pairs.
// Lookup is combinational; a write lands at the clock edge.
// Assumes the caller never writes a key into a second entry and uses
// rsv_en/rsv_idx to hide an entry it is about to fill from the free search.
module knock_state_table
    import knock_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [KEY_W-1:0]    lk_key,
    output logic [ENTRIES-1:0]  lk_hitvec,
    output logic                lk_hit,
    output logic [IDX_W-1:0]    lk_idx,
    output kstate_t             lk_state,
    input  logic                rsv_en,
    input  logic [IDX_W-1:0]    rsv_idx,
    output logic                free_ok,
    output logic [IDX_W-1:0]    free_idx,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [KEY_W-1:0]    wr_key,
    input  kstate_t             wr_state
);
    logic [ENTRIES-1:0] ent_vld;
    logic [KEY_W-1:0]   ent_key [ENTRIES];
    kstate_t            ent_st  [ENTRIES];
    logic [ENTRIES-1:0] freevec;

    // Per-entry key match and free flag.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        assign lk_hitvec[g] = ent_vld[g] && (ent_key[g] == lk_key);
        assign freevec[g]   = !ent_vld[g] && !(rsv_en && (rsv_idx == IDX_W'(g)));
    end

    // Encode the hit entry and the lowest free entry.
    always_comb begin
        lk_idx   = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (lk_hitvec[i]) lk_idx   = IDX_W'(i);
            if (freevec[i])   free_idx = IDX_W'(i);
        end
        lk_hit   = |lk_hitvec;
        free_ok  = |freevec;
        lk_state = lk_hit ? ent_st[lk_idx] : KS_IDLE;
    end

    // Entry occupancy; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
        end else if (wr_en) begin
            ent_vld[wr_idx] <= 1'b1;
        end
    end

    // Entry payload; only meaningful while its valid bit is set.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ent_key[wr_idx] <= wr_key;
            ent_st[wr_idx]  <= wr_state;
        end
    end
endmodule

// File: rtl/knock_filter.sv
// Per-source port knocking filter, two register stages.
// Stage 1 holds the looked-up header. Its transition is evaluated and
// written back as it moves into stage 2, which holds the verdict.
// A header looked up behind a same-source header in stage 1 takes
// that header's pending result instead of the stale table value.
// Assumes a synchronous active-low reset.
module knock_filter
    import knock_pkg::*;
#(
    parameter int                   ADDR_W    = 32,
    parameter int                   PORT_W    = 16,
    parameter int                   ENTRIES   = 16,
    parameter logic [4*PORT_W-1:0]  KNOCK_SEQ = {16'd8456, 16'd7345, 16'd6234, 16'd5123},
    parameter logic [PORT_W-1:0]    SVC_PORT  = 16'd22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [ADDR_W-1:0]   in_src,
    input  logic [PORT_W-1:0]   in_dport,
    output logic                out_valid,
    input  logic                out_ready,
    output logic                out_fwd
);
    localparam int IDX_W = $clog2(ENTRIES);

    // Stage 1 state.
    logic               s1_valid;
    logic [ADDR_W-1:0]  s1_src;
    logic [PORT_W-1:0]  s1_dport;
    logic               s1_hit;
    logic               s1_alloc;
    logic [IDX_W-1:0]   s1_idx;
    kstate_t            s1_state;

    // Table lookup results.
    logic [ENTRIES-1:0] t_hitvec;
    logic               t_hit;
    logic [IDX_W-1:0]   t_idx;
    kstate_t            t_state;
    logic               t_free_ok;
    logic [IDX_W-1:0]   t_free_idx;

    // Effective lookup after forwarding.
    logic               e_hit;
    logic               e_alloc;
    logic [IDX_W-1:0]   e_idx;
    kstate_t            e_state;

    kstate_t            nx_state;
    logic               nx_fwd;
    logic               s1_wr;
    logic               s2_ready;
    logic               s1_adv;
    logic               accept;
    logic               byp;

    assign s2_ready = !out_valid || out_ready;
    assign s1_adv   = s1_valid && s2_ready;
    assign in_ready = !s1_valid || s2_ready;
    assign accept   = in_valid && in_ready;
    assign s1_wr    = s1_valid && (s1_hit || s1_alloc);
    assign byp      = s1_valid && (s1_src == in_src);

    knock_state_table #(
        .ENTRIES (ENTRIES),
        .KEY_W   (ADDR_W)
    ) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_key    (in_src),
        .lk_hitvec (t_hitvec),
        .lk_hit    (t_hit),
        .lk_idx    (t_idx),
        .lk_state  (t_state),
        .rsv_en    (s1_valid && !s1_hit && s1_alloc),
        .rsv_idx   (s1_idx),
        .free_ok   (t_free_ok),
        .free_idx  (t_free_idx),
        .wr_en     (s1_adv && s1_wr),
        .wr_idx    (s1_idx),
        .wr_key    (s1_src),
        .wr_state  (nx_state)
    );

    knock_xfsm #(
        .PORT_W    (PORT_W),
        .KNOCK_SEQ (KNOCK_SEQ),
        .SVC_PORT  (SVC_PORT)
    ) i_xfsm (
        .cur_state (s1_state),
        .dport     (s1_dport),
        .nxt_state (nx_state),
        .fwd       (nx_fwd)
    );

    // Choose between the table and the pending stage-1 result.
    always_comb begin
        if (byp) begin
            e_hit   = s1_wr;
            e_idx   = s1_idx;
            e_state = s1_wr ? nx_state : KS_IDLE;
            e_alloc = !s1_wr && t_free_ok;
        end else begin
            e_hit   = t_hit;
            e_idx   = t_hit ? t_idx : t_free_idx;
            e_state = t_state;
            e_alloc = !t_hit && t_free_ok;
        end
    end

    // Stage-1 occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
        end else if (accept) begin
            s1_valid <= 1'b1;
        end else if (s1_adv) begin
            s1_valid <= 1'b0;
        end
    end

    // Stage-1 header and lookup capture.
    always_ff @(posedge clk) begin
        if (accept) begin
            s1_src   <= in_src;
            s1_dport <= in_dport;
            s1_hit   <= e_hit;
            s1_alloc <= e_alloc;
            s1_idx   <= e_idx;
            s1_state <= e_state;
        end
    end

    // Stage-2 verdict register, held while the consumer stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fwd   <= 1'b0;
        end else if (s2_ready) begin
            out_valid <= s1_valid;
            out_fwd   <= s1_valid && nx_fwd;
        end
    end
endmodule

// File: rtl/knock_filter_chk.sv
// Protocol and invariant checks for knock_filter, bound into every instance.
// Assumes a synchronous active-low reset asserted from time zero.
module knock_filter_chk #(
    parameter int               PORT_W   = 16,
    parameter int               ENTRIES  = 16,
    parameter logic [PORT_W-1:0] SVC_PORT = 16'd22
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_ready,
    input logic                 out_valid,
    input logic                 out_ready,
    input logic                 out_fwd,
    input logic                 s1_valid,
    input logic [PORT_W-1:0]    s1_dport,
    input logic                 s2_ready,
    input logic [ENTRIES-1:0]   hitvec
);
    AST_HOLD_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_fwd)); // R12

    AST_FULL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid && out_valid && !out_ready |-> !in_ready); // R12

    AST_READY_WHEN_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R11

    AST_FWD_SERVICE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fwd && $past(s2_ready) |-> $past(s1_dport) == SVC_PORT); // R6

    AST_SINGLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hitvec)); // R13
endmodule

bind knock_filter knock_filter_chk #(
    .PORT_W   (PORT_W),
    .ENTRIES  (ENTRIES),
    .SVC_PORT (SVC_PORT)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_fwd   (out_fwd),
    .s1_valid  (s1_valid),
    .s1_dport  (s1_dport),
    .s2_ready  (s2_ready),
    .hitvec    (t_hitvec)
);

// File: tb/test_knock_filter.sv
// Self-checking bench for knock_filter: directed scenarios plus seeded
// random traffic, scored against a behavioural model of the requirements.
module test_knock_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_src = '0;
    logic [15:0] in_dport = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic        out_fwd;

    int n_chk = 0;
    int n_err = 0;
    bit exp_q[$];
    string tag_q[$];

    // Behavioural model: 16 entries, never freed.
    logic [31:0] mkey [16];
    int          mst  [16];
    int          mcnt = 0;

    always #2 clk = ~clk;

    knock_filter i_knock_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_src    (in_src),
        .in_dport  (in_dport),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_fwd   (out_fwd)
    );

    function automatic int knock_port(int step);
        case (step)
            0: return 5123;
            1: return 6234;
            2: return 7345;
            default: return 8456;
        endcase
    endfunction

    function automatic int find_src(logic [31:0] s);
        for (int i = 0; i < mcnt; i++) if (mkey[i] == s) return i;
        return -1;
    endfunction

    // Apply one header to the model and return the expected verdict.
    function automatic bit model_step(logic [31:0] s, logic [15:0] p);
        int idx;
        int st;
        bit f;
        idx = find_src(s);
        if (idx < 0) begin
            if (mcnt >= 16) return 1'b0;
            idx = mcnt;
            mkey[idx] = s;
            mst[idx] = 0;
            mcnt++;
        end
        st = mst[idx];
        f = 1'b0;
        if (st == 4) begin
            if (p == 16'd22) f = 1'b1;
            else mst[idx] = 0;
        end else if (int'(p) == knock_port(st)) begin
            mst[idx] = st + 1;
        end else begin
            mst[idx] = 0;
        end
        return f;
    endfunction

    function automatic logic [15:0] next_port(logic [31:0] s);
        int idx;
        idx = find_src(s);
        if (idx < 0) return 16'd5123;
        if (mst[idx] == 4) return 16'd22;
        return 16'(knock_port(mst[idx]));
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, then score the handshakes of the coming edge.
    task automatic drive(bit v, logic [31:0] s, logic [15:0] p, bit ordy,
                         string tag, output bit took);
        bit e;
        string t;
        @(negedge clk);
        in_valid  = v;
        in_src    = s;
        in_dport  = p;
        out_ready = ordy;
        #1;
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R11 (unexpected verdict)", 1, 0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(out_fwd === e, t, int'(out_fwd), int'(e));
            end
        end
        took = v && in_ready;
        if (took) begin
            exp_q.push_back(model_step(s, p));
            tag_q.push_back(tag);
        end
    endtask

    task automatic send(logic [31:0] s, logic [15:0] p, string tag, output int tries);
        bit took;
        tries = 0;
        do begin
            drive(1'b1, s, p, 1'b1, tag, took);
            tries++;
        end while (!took && tries < 50);
    endtask

    task automatic idle(int n);
        bit took;
        repeat (n) drive(1'b0, '0, '0, 1'b1, "", took);
    endtask

    task automatic knock_all(logic [31:0] s, string tag, bit gaps);
        int tr;
        for (int k = 0; k < 4; k++) begin
            send(s, 16'(knock_port(k)), tag, tr);
            if (gaps) idle(3);
        end
    endtask

    initial begin
        #(4 * 200000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] src_a, src_b, src_c, src_d, src_e;
        int tr;
        int total;
        bit took;
        bit held;
        src_a = 32'h0A000001;
        src_b = 32'h0A000002;
        src_c = 32'h0A000003;
        src_d = 32'h0A000004;
        src_e = 32'hAC100011;
        void'($urandom(32'd4242));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(in_ready === 1'b1, "R1 in_ready", int'(in_ready), 1);

        // R2 with gaps (no forwarding), then R4 repeat.
        knock_all(src_a, "R2", 1'b1);
        send(src_a, 16'd22, "R4 first", tr);
        idle(2);
        send(src_a, 16'd22, "R4 repeat", tr);
        idle(3);

        // R5: leave open state via another port.
        send(src_a, 16'd80, "R5 other port", tr);
        send(src_a, 16'd22, "R5 after close", tr);
        idle(3);

        // R3: wrong knock mid-sequence restarts.
        send(src_b, 16'd5123, "R3", tr);
        send(src_b, 16'd6234, "R3", tr);
        send(src_b, 16'd9999, "R3 wrong knock", tr);
        send(src_b, 16'd7345, "R3", tr);
        send(src_b, 16'd8456, "R3", tr);
        send(src_b, 16'd22, "R3 not open", tr);
        idle(3);

        // R10 + R11: back-to-back same source, one per cycle.
        total = 0;
        for (int k = 0; k < 4; k++) begin
            send(src_c, 16'(knock_port(k)), "R10", tr);
            total += tr;
        end
        send(src_c, 16'd22, "R10 opened back-to-back", tr);
        total += tr;
        chk(total == 5, "R11 one header per cycle", total, 5);
        idle(1);
        chk(out_valid === 1'b1, "R11 two-edge latency", int'(out_valid), 1);
        idle(3);

        // R6 and R8: new source starts idle, then opens.
        send(src_d, 16'd22, "R6 port 22 while idle", tr);
        knock_all(src_d, "R8", 1'b0);
        send(src_d, 16'd22, "R8 new source opens", tr);
        idle(3);

        // R7: interleave two sources.
        send(src_a, 16'd5123, "R7", tr);
        send(src_b, 16'd5123, "R7", tr);
        send(src_a, 16'd6234, "R7", tr);
        send(src_b, 16'd1111, "R7", tr);
        send(src_a, 16'd7345, "R7", tr);
        send(src_b, 16'd7345, "R7", tr);
        send(src_a, 16'd8456, "R7", tr);
        send(src_a, 16'd22, "R7 source a", tr);
        send(src_b, 16'd22, "R7 source b", tr);
        idle(3);

        // R12: stall the consumer with two headers inside.
        drive(1'b1, src_a, 16'd22, 1'b0, "R12 stalled verdict", took);
        drive(1'b1, src_d, 16'd80, 1'b0, "R12 second", took);
        drive(1'b1, src_b, 16'd5123, 1'b0, "R12 blocked", took);
        chk(took == 1'b0, "R12 in_ready low when full", int'(took), 0);
        held = out_fwd;
        chk(out_valid === 1'b1, "R12 out_valid", int'(out_valid), 1);
        repeat (3) drive(1'b1, src_b, 16'd5123, 1'b0, "R12 blocked", took);
        chk(out_valid === 1'b1 && out_fwd === held, "R12 hold", int'(out_fwd), int'(held));
        chk(took == 1'b0, "R12 still blocked", int'(took), 0);
        idle(4);

        // Random traffic over a pool of twelve sources, random stalls.
        for (int n = 0; n < 700; n++) begin
            logic [31:0] s;
            logic [15:0] p;
            int r;
            s = 32'hC0A80000 + 32'($urandom % 12);
            r = $urandom % 10;
            if (r < 6) p = next_port(s);
            else if (r < 8) p = 16'd22;
            else p = 16'($urandom);
            drive(($urandom % 5) != 0, s, p, ($urandom % 4) != 0, "R7 random", took);
        end
        idle(5);

        // R9: table full, new source cannot open; old one unaffected.
        chk(mcnt == 16, "R9 table filled by stimulus", mcnt, 16);
        knock_all(src_e, "R9 full knock", 1'b0);
        send(src_e, 16'd22, "R9 full no entry", tr);
        send(src_a, 16'd22, "R9 existing source", tr);

        for (int w = 0; w < 20 && exp_q.size() != 0; w++) idle(1);
        chk(exp_q.size() == 0, "R11 all verdicts returned", exp_q.size(), 0);

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule